// File: doc/BRIEF.md
# Two-Clock Tile Boundary FIFO

This block carries data words from a write clock domain into an unrelated read clock domain inside one processing tile. The write clock travels with the data from the sending neighbour, and the read clock comes from the tile's own oscillator. The only paths between the two domains are the write and read pointers. Each pointer is held in Gray code and passes through a flip-flop chain. A run-time select sets the number of active stages in that chain to two, three or four.

The write side uses coarse-grained flow control. A word is stored on every write-clock edge where `in_valid` is high, and no per-word acknowledge is returned. To throttle the sender, the block raises `in_hold` once occupancy, as seen in the write domain, reaches the depth minus a programmable margin. The margin is sized to cover the words the sender still has in flight while the hold crosses back. A word that arrives while the FIFO is truly full is discarded and sets a sticky overflow flag.

The read side is a valid/ready stream. `out_valid` is high whenever the read domain sees data. A word leaves on a read-clock edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. `out_ready` may be high at any time and has no effect while `out_valid` is low.

Top module: `xdom_fifo`

## Requirements
- R1: While reset is applied and after it is released, with no writes, `out_valid`, `in_hold` and `overflow` are all 0.
- R2: Words come out of `out_data` in the order they were written, and none are lost or repeated while occupancy stays at or below DEPTH.
- R3: When `in_valid` is high and the FIFO holds DEPTH words, the word is dropped and `overflow` goes to 1. `overflow` then stays 1 until reset.
- R4: When `out_ready` is high while `out_valid` is low, the read pointer does not move, so the next word written is the next word read.
- R5: `in_hold` is 1 exactly when the write-domain occupancy (write pointer minus synchronized read pointer) is at least DEPTH minus `hold_margin`.
- R6: The `sync_sel` code sets the number of synchronizer stages: 0 gives 2, 1 gives 3, and 2 or 3 give 4. After a write into an empty FIFO, `out_valid` rises on exactly that many read-clock edges, counted from the first read edge after the write edge.
- R7: Each Gray-coded pointer changes by at most one bit per clock of its own domain.
- R8: `sync_sel` may change only while the FIFO is empty. It must stay stable while `out_valid` is held high.
- R9: While `out_valid` is 1 and `out_ready` is 0, on the next read edge `out_valid` stays 1 and `out_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| sync_sel | input | 2 | Synchronizer depth code (0:2, 1:3, 2/3:4 stages) |
| wclk | input | 1 | Write clock, forwarded with the data |
| in_valid | input | 1 | Word present on `in_data` this write edge |
| in_data | input | DATA_W | Write data |
| hold_margin | input | ADDR_W+1 | Free-space margin for the hold threshold |
| in_hold | output | 1 | Back-pressure request to the sender |
| overflow | output | 1 | Sticky flag: a write was dropped while full |
| rclk | input | 1 | Read clock, local oscillator |
| out_valid | output | 1 | Read data available |
| out_ready | input | 1 | Consumer accepts the word on this read edge |
| out_data | output | DATA_W | Read data |

## Verification
The bench builds the block with DATA_W=16 and ADDR_W=3. A depth of eight lets a few writes reach both the full condition and the hold threshold. The write clock runs at 10 ns and the read clock at 14 ns, so their edges drift against each other. For every `sync_sel` code, the bench counts read edges from a write into an empty FIFO, which separates the 2-, 3- and 4-stage taps exactly. With `hold_margin` set to 3, the bench finds the exact word on which the hold asserts. It also exercises dropping on overflow, ignored empty reads, and the release of the hold once the FIFO has drained.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

  localparam int MIN_SYNC = 2;
  localparam int MAX_SYNC = 4;

  typedef enum logic [1:0] {
    SYNC_2  = 2'd0,
    SYNC_3  = 2'd1,
    SYNC_4  = 2'd2,
    SYNC_4B = 2'd3
  } sync_depth_e;

  // number of active stages for a depth code
  function automatic int stage_count(input logic [1:0] code);
    int n;
    n = MIN_SYNC + int'(code);
    if (n > MAX_SYNC) n = MAX_SYNC;
    return n;
  endfunction

endpackage

// File: rtl/xdom_rst_sync.sv
module xdom_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= 2'b00;
    else         sh <= {sh[0], 1'b1};
  end

  assign rst_n = sh[1];
endmodule

// File: rtl/xdom_sync_chain.sv
module xdom_sync_chain
  import xdom_fifo_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [MAX_SYNC];

  for (genvar i = 0; i < MAX_SYNC; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= '0;
        else        st[i] <= st[i-1];
      end
    end
  end

  // tap the chain at the selected stage
  always_comb begin
    q = st[MAX_SYNC-1];
    for (int k = 0; k < MAX_SYNC; k++) begin
      if (k == stage_count(sel) - 1) q = st[k];
    end
  end
endmodule

// File: rtl/xdom_wr_side.sv
module xdom_wr_side #(
  parameter int ADDR_W = 3,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PTR_W-1:0] margin,
  input  logic [PTR_W-1:0] rgray_s,
  output logic [PTR_W-1:0] wbin,
  output logic [PTR_W-1:0] wgray,
  output logic             we,
  output logic             in_hold,
  output logic             overflow
);
  logic [PTR_W-1:0] rbin_s;
  logic [PTR_W-1:0] occ;
  logic [PTR_W-1:0] wbin_n;
  logic             full;

  always_comb begin
    rbin_s[PTR_W-1] = rgray_s[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign occ     = wbin - rbin_s;
  assign full    = (occ == PTR_W'(DEPTH));
  assign we      = in_valid && !full;
  assign wbin_n  = wbin + PTR_W'(we);
  assign in_hold = ({1'b0, occ} + {1'b0, margin}) >= (PTR_W+1)'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      overflow <= 1'b0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
      if (in_valid && full) overflow <= 1'b1;
    end
  end

  // R3: a word offered while full leaves the pointer where it was
  a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> (wbin == $past(wbin)));
  // R3: the overflow flag never clears without reset
  a_r3_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R2: an accepted word advances the pointer by one
  a_r2_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !full) |=> (wbin == $past(wbin) + PTR_W'(1)));
  // R7: write Gray pointer changes by at most one bit
  a_r7_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/xdom_rd_side.sv
module xdom_rd_side #(
  parameter int ADDR_W = 3,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_ready,
  input  logic [PTR_W-1:0] wgray_s,
  output logic [PTR_W-1:0] rbin,
  output logic [PTR_W-1:0] rgray,
  output logic             out_valid
);
  logic             rd_en;
  logic [PTR_W-1:0] rbin_n;

  assign out_valid = (rgray != wgray_s);
  assign rd_en     = out_valid && out_ready;
  assign rbin_n    = rbin + PTR_W'(rd_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
    end
  end

  // R4: a read request while empty leaves the pointer alone
  a_r4_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready) |=> (rbin == $past(rbin)));
  // R7: read Gray pointer changes by at most one bit
  a_r7_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R9: a stalled word stays offered
  a_r9_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo
  import xdom_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              arst_n,
  input  logic [1:0]        sync_sel,
  input  logic              wclk,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [PTR_W-1:0]  hold_margin,
  output logic              in_hold,
  output logic              overflow,
  input  logic              rclk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic             wrst_n, rrst_n;
  logic [PTR_W-1:0] wbin, wgray, wgray_s;
  logic [PTR_W-1:0] rbin, rgray, rgray_s;
  logic             we;
  logic [DATA_W-1:0] mem [DEPTH];

  xdom_rst_sync u_wrst (.clk(wclk), .arst_n(arst_n), .rst_n(wrst_n));
  xdom_rst_sync u_rrst (.clk(rclk), .arst_n(arst_n), .rst_n(rrst_n));

  xdom_sync_chain #(.W(PTR_W)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .sel(sync_sel), .d(rgray), .q(rgray_s));
  xdom_sync_chain #(.W(PTR_W)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .sel(sync_sel), .d(wgray), .q(wgray_s));

  xdom_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .in_valid(in_valid), .margin(hold_margin),
    .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray), .we(we),
    .in_hold(in_hold), .overflow(overflow));

  xdom_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .out_ready(out_ready), .wgray_s(wgray_s),
    .rbin(rbin), .rgray(rgray), .out_valid(out_valid));

  always_ff @(posedge wclk) begin
    if (we) mem[wbin[ADDR_W-1:0]] <= in_data;
  end

  assign out_data = mem[rbin[ADDR_W-1:0]];

  // R9: stalled data does not change
  a_r9_data_held: assert property (@(posedge rclk) disable iff (!rrst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
  // R8: depth select is static while data is being offered
  a_r8_sel_static: assert property (@(posedge rclk) disable iff (!rrst_n)
    (out_valid && $past(out_valid)) |-> $stable(sync_sel));
  // R1: nothing is offered straight out of reset
  a_r1_reset_empty: assert property (@(posedge rclk)
    !rrst_n |=> !out_valid);
endmodule

// File: tb/xdom_fifo_tb.sv
module xdom_fifo_tb;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;

  // row: {sync_sel[1:0], words[5:0], expected stages[3:0]}
  localparam logic [11:0] VEC [5] = '{
    {2'd0, 6'd3, 4'd2},
    {2'd1, 6'd5, 4'd3},
    {2'd2, 6'd8, 4'd4},
    {2'd3, 6'd2, 4'd4},
    {2'd0, 6'd6, 4'd2}
  };

  logic          arst_n = 1'b0;
  logic [1:0]    sync_sel = 2'd0;
  logic          wclk = 1'b0, rclk = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [PW-1:0] hold_margin = PW'(3);
  logic          in_hold, overflow, out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int checks = 0, fails = 0;
  logic [DW-1:0] seq = 16'h1000;
  logic [DW-1:0] expq [$];
  bit done = 0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  xdom_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .arst_n(arst_n), .sync_sel(sync_sel), .wclk(wclk), .in_valid(in_valid),
    .in_data(in_data), .hold_margin(hold_margin), .in_hold(in_hold),
    .overflow(overflow), .rclk(rclk), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_word();
    @(negedge wclk);
    in_valid = 1'b1;
    in_data  = seq;
    expq.push_back(seq);
    seq++;
    @(posedge wclk);
    #1 in_valid = 1'b0;
  endtask

  // read until idle; returns number of words read, checks order (R2)
  task automatic drain(output int got);
    int idle;
    got = 0;
    idle = 0;
    while (idle < 12) begin
      @(negedge rclk);
      if (out_valid) begin
        idle = 0;
        if (expq.size() > 0) begin
          chk(out_data == expq[0], "R2 order", int'(out_data), int'(expq[0]));
          void'(expq.pop_front());
        end else begin
          chk(1'b0, "R2 extra word", int'(out_data), 0);
        end
        out_ready = 1'b1;
        @(posedge rclk);
        #1 out_ready = 1'b0;
        got++;
      end else begin
        idle++;
      end
    end
  endtask

  task automatic do_reset();
    arst_n = 1'b0;
    #40;
    chk(!out_valid && !in_hold && !overflow, "R1 in reset",
        {out_valid, in_hold, overflow}, 0);
    @(negedge wclk) arst_n = 1'b1;
    repeat (6) @(posedge rclk);
    #1;
    chk(!out_valid && !in_hold && !overflow, "R1 after release",
        {out_valid, in_hold, overflow}, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int got;
    int n_w;
    int lat;
    do_reset();

    // table walk: sync depth latency (R6) then ordered transfer (R2)
    foreach (VEC[i]) begin
      sync_sel = VEC[i][11:10];
      n_w      = int'(VEC[i][9:4]);
      lat      = int'(VEC[i][3:0]);
      repeat (8) @(posedge wclk);
      put_word();
      for (int k = 1; k < lat; k++) @(posedge rclk);
      #1 chk(!out_valid, "R6 early", out_valid, 0);
      @(posedge rclk);
      #1 chk(out_valid, "R6 at depth", out_valid, 1);
      // R9: stalled word held over a few read edges
      repeat (2) @(posedge rclk);
      #1 chk(out_valid && out_data == expq[0], "R9 hold", int'(out_data), int'(expq[0]));
      for (int k = 1; k < n_w; k++) put_word();
      drain(got);
      chk(got == n_w, "R2 count", got, n_w);
    end

    // R5: hold threshold, margin 3 with depth 8 -> at 5 words
    sync_sel = 2'd0;
    repeat (10) @(posedge wclk);
    for (int k = 0; k < 4; k++) put_word();
    chk(!in_hold, "R5 below threshold", in_hold, 0);
    put_word();
    chk(in_hold, "R5 at threshold", in_hold, 1);
    drain(got);
    chk(got == 5, "R5 drained count", got, 5);
    repeat (8) @(posedge wclk);
    #1 chk(!in_hold, "R5 released", in_hold, 0);

    // R3: overflow drop and stickiness
    for (int k = 0; k < DEPTH; k++) put_word();
    chk(!overflow, "R3 no flag at full", overflow, 0);
    @(negedge wclk);
    in_valid = 1'b1;
    in_data  = 16'hDEAD;
    @(posedge wclk);
    #1 in_valid = 1'b0;
    chk(overflow, "R3 flag set", overflow, 1);
    drain(got);
    chk(got == DEPTH, "R3 dropped word", got, DEPTH);
    chk(overflow, "R3 sticky", overflow, 1);

    // R4: reads while empty have no effect
    @(negedge rclk) out_ready = 1'b1;
    repeat (5) @(posedge rclk);
    #1 chk(!out_valid, "R4 still empty", out_valid, 0);
    out_ready = 1'b0;
    put_word();
    drain(got);
    chk(got == 1, "R4 single word", got, 1);

    // R1: reset clears the sticky flag
    do_reset();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule